// File: doc/BRIEF.md
# NAND Bad-Block Scanner

This block runs once after reset and builds a table of which erase blocks of a small NAND array can be used. It steps through every erase block in ascending order and reads a marker byte through a simple read request/response port. The marker sits at column 0 of the first page of the block and, if that byte reads as erased, also at column 0 of the second page. A block whose marker is anything other than the erased value FFh is recorded as bad. Block 0 is always treated as good.

When the walk is complete, a done flag rises. Other logic then queries the table through a one-cycle lookup port and reads a count of distinct bad blocks. If more blocks are bad than the array is allowed to have, a device-failure flag is raised. At any time, including while the scan is still running, a failed program or erase can add its block to the same table, so that the block is never used again.

Top module: `bbs_scanner`

## Requirements
- R1: While reset is held and just after it, scan_done, bad_count, dev_fail, lk_bad and rd_req are all 0, and every block is recorded as good.
- R2: The marker read for block b and page p uses address b*4096 + p*128, so the block sits in bits 18..12, the page row in bits 11..7 and column 0 in bits 6..0. Blocks are read in ascending order from 0 to 127. rd_req and rd_addr stay stable from the request until the cycle in which rd_rsp_valid is high.
- R3: A block is recorded bad when the page-0 marker or the page-1 marker differs from FFh. The page-1 marker is read only when the page-0 marker read FFh.
- R4: Block 0 always looks up as good, whatever its marker reads and whatever failures are reported for it.
- R5: scan_done rises after the response to the last marker read of block 127 and then stays high. After that, no further reads are requested.
- R6: lk_bad shows the state of block lk_block one clock after lk_block is presented (1 = bad). lk_bad stays 0 while scan_done is low.
- R7: bad_count is the number of distinct bad blocks. dev_fail is 1 exactly when bad_count exceeds 3.
- R8: A cycle with fail_valid high marks block fail_block bad. This works during the scan and after it. A block that is already bad is not counted a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | Marker read request, held until the response arrives |
| rd_addr | output | 19 | Byte address of the marker being read |
| rd_rsp_valid | input | 1 | One-cycle response strobe |
| rd_rsp_data | input | 8 | Marker byte returned with the strobe |
| fail_valid | input | 1 | Run-time program/erase failure report |
| fail_block | input | 7 | Block that failed |
| lk_block | input | 7 | Block to look up |
| lk_bad | output | 1 | Registered lookup result, 1 = bad |
| scan_done | output | 1 | Scan complete |
| bad_count | output | 8 | Number of distinct bad blocks |
| dev_fail | output | 1 | More than 3 bad blocks |

## Verification
The bench sets a marker of 00h in block 0, which must be ignored. It places a bad page-0 marker in an early block, so the bench can confirm that the second read is skipped; a design that always read both pages would issue an unexpected address. A bad page-1 marker sits in another block, and one in block 127, which catches a scan that stops one block early or forgets the second page. A failure is reported for a block before the scan reaches it, and a second failure is reported for a block that is already bad. A design that double-counts would then show the wrong bad_count and could trip dev_fail at exactly three bad blocks instead of four. Lookups made before done must read 0, and a failure reported for block 0 must not change its state or the count.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [1:0] {
    SC_GAP  = 2'd0,
    SC_REQ  = 2'd1,
    SC_DONE = 2'd2
  } scan_state_t;
endpackage

// File: rtl/bbs_rst_sync.sv
module bbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bbs_scan_seq.sv
module bbs_scan_seq
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS = 128,
  parameter int ROWS_PER_BLK = 32,
  parameter int ROW_BYTES = 128,
  parameter int MARK_PAGES = 2,
  parameter logic [7:0] ERASED = 8'hFF,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = $clog2(ROWS_PER_BLK),
  localparam int COL_W = $clog2(ROW_BYTES),
  localparam int ADDR_W = BLK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data,
  output logic              mark_en,
  output logic [BLK_W-1:0]  mark_blk,
  output logic              scan_done
);
  localparam int PG_W = (MARK_PAGES > 1) ? $clog2(MARK_PAGES) : 1;
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [PG_W-1:0]  LAST_PG  = PG_W'(MARK_PAGES - 1);

  scan_state_t      state_q, state_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [PG_W-1:0]  pg_q, pg_d;
  logic             marker_bad;

  assign marker_bad = (rd_rsp_data != ERASED);

  always_comb begin
    state_d = state_q;
    blk_d   = blk_q;
    pg_d    = pg_q;
    mark_en = 1'b0;
    case (state_q)
      SC_GAP: state_d = SC_REQ;
      SC_REQ: begin
        if (rd_rsp_valid) begin
          mark_en = marker_bad;
          if (marker_bad || pg_q == LAST_PG) begin
            pg_d = '0;
            if (blk_q == LAST_BLK) begin
              state_d = SC_DONE;
            end else begin
              blk_d   = blk_q + 1'b1;
              state_d = SC_GAP;
            end
          end else begin
            pg_d    = pg_q + 1'b1;
            state_d = SC_GAP;
          end
        end
      end
      default: state_d = SC_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_GAP;
      blk_q   <= '0;
      pg_q    <= '0;
    end else begin
      state_q <= state_d;
      blk_q   <= blk_d;
      pg_q    <= pg_d;
    end
  end

  assign rd_req    = (state_q == SC_REQ);
  assign rd_addr   = {blk_q, ROW_W'(pg_q), {COL_W{1'b0}}};
  assign mark_blk  = blk_q;
  assign scan_done = (state_q == SC_DONE);
endmodule

// File: rtl/bbs_bad_table.sv
module bbs_bad_table #(
  parameter int NUM_BLOCKS = 128,
  parameter int MAX_BAD = 3,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_a_en,
  input  logic [BLK_W-1:0] set_a_blk,
  input  logic             set_b_en,
  input  logic [BLK_W-1:0] set_b_blk,
  input  logic             lk_en,
  input  logic [BLK_W-1:0] lk_blk,
  output logic             lk_bad,
  output logic [CNT_W-1:0] bad_count,
  output logic             dev_fail
);
  logic [NUM_BLOCKS-1:0] map_q, map_d;
  logic [CNT_W-1:0]      count_q, count_d;
  logic                  lk_q, lk_d;
  logic                  a_new, b_new;

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_bit
    if (i == 0) begin : g_pinned
      assign map_d[i] = 1'b0;
    end else begin : g_settable
      assign map_d[i] = map_q[i]
                      | (set_a_en && set_a_blk == BLK_W'(i))
                      | (set_b_en && set_b_blk == BLK_W'(i));
    end
  end

  always_comb begin
    a_new   = set_a_en && (set_a_blk != '0) && !map_q[set_a_blk];
    b_new   = set_b_en && (set_b_blk != '0) && !map_q[set_b_blk]
              && !(a_new && set_a_blk == set_b_blk);
    count_d = count_q + CNT_W'(a_new) + CNT_W'(b_new);
    lk_d    = lk_en ? map_q[lk_blk] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q   <= '0;
      count_q <= '0;
      lk_q    <= 1'b0;
    end else begin
      map_q   <= map_d;
      count_q <= count_d;
      lk_q    <= lk_d;
    end
  end

  assign lk_bad    = lk_q;
  assign bad_count = count_q;
  assign dev_fail  = (count_q > CNT_W'(MAX_BAD));
endmodule

// File: rtl/bbs_scanner.sv
module bbs_scanner #(
  parameter int NUM_BLOCKS = 128,
  parameter int ROWS_PER_BLK = 32,
  parameter int ROW_BYTES = 128,
  parameter int MARK_PAGES = 2,
  parameter int MAX_BAD = 3,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ADDR_W = BLK_W + $clog2(ROWS_PER_BLK) + $clog2(ROW_BYTES),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data,
  input  logic              fail_valid,
  input  logic [BLK_W-1:0]  fail_block,
  input  logic [BLK_W-1:0]  lk_block,
  output logic              lk_bad,
  output logic              scan_done,
  output logic [CNT_W-1:0]  bad_count,
  output logic              dev_fail
);
  logic             rst_int_n;
  logic             mark_en;
  logic [BLK_W-1:0] mark_blk;

  bbs_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bbs_scan_seq #(
    .NUM_BLOCKS   (NUM_BLOCKS),
    .ROWS_PER_BLK (ROWS_PER_BLK),
    .ROW_BYTES    (ROW_BYTES),
    .MARK_PAGES   (MARK_PAGES),
    .ERASED       (8'hFF)
  ) i_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .mark_en      (mark_en),
    .mark_blk     (mark_blk),
    .scan_done    (scan_done)
  );

  bbs_bad_table #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .MAX_BAD    (MAX_BAD)
  ) i_table (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .set_a_en  (mark_en),
    .set_a_blk (mark_blk),
    .set_b_en  (fail_valid),
    .set_b_blk (fail_block),
    .lk_en     (scan_done),
    .lk_blk    (lk_block),
    .lk_bad    (lk_bad),
    .bad_count (bad_count),
    .dev_fail  (dev_fail)
  );
endmodule

// File: rtl/bbs_scanner_chk.sv
module bbs_scanner_chk #(
  parameter int NUM_BLOCKS = 128,
  parameter int ROWS_PER_BLK = 32,
  parameter int ROW_BYTES = 128,
  parameter int MARK_PAGES = 2,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = $clog2(ROWS_PER_BLK),
  localparam int COL_W = $clog2(ROW_BYTES),
  localparam int ADDR_W = BLK_W + ROW_W + COL_W,
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_rsp_valid,
  input logic [BLK_W-1:0]  lk_block,
  input logic              lk_bad,
  input logic              scan_done,
  input logic [CNT_W-1:0]  bad_count
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_rsp_valid |=> rd_req && $stable(rd_addr)); // R2
  AST_MARKER_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[COL_W-1:0] == '0); // R2
  AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[COL_W+ROW_W-1:COL_W] < ROW_W'(MARK_PAGES)); // R3
  AST_BLOCK0_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    lk_block == '0 |=> !lk_bad); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> scan_done); // R5
  AST_NO_READ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !rd_req); // R5
  AST_LOOKUP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |=> !lk_bad); // R6
  AST_COUNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bad_count >= $past(bad_count)); // R7
endmodule

bind bbs_scanner bbs_scanner_chk #(
  .NUM_BLOCKS   (NUM_BLOCKS),
  .ROWS_PER_BLK (ROWS_PER_BLK),
  .ROW_BYTES    (ROW_BYTES),
  .MARK_PAGES   (MARK_PAGES)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req       (rd_req),
  .rd_addr      (rd_addr),
  .rd_rsp_valid (rd_rsp_valid),
  .lk_block     (lk_block),
  .lk_bad       (lk_bad),
  .scan_done    (scan_done),
  .bad_count    (bad_count)
);

// File: tb/test_bbs_scanner.sv
module test_bbs_scanner;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_req;
  logic [18:0] rd_addr;
  logic        rd_rsp_valid;
  logic [7:0]  rd_rsp_data;
  logic        fail_valid;
  logic [6:0]  fail_block;
  logic [6:0]  lk_block;
  logic        lk_bad;
  logic        scan_done;
  logic [7:0]  bad_count;
  logic        dev_fail;

  int errors = 0;
  int checks = 0;
  logic [7:0]  mk0 [128];
  logic [7:0]  mk1 [128];
  logic [18:0] exp_q [$];

  always #2 clk = ~clk;

  bbs_scanner i_bbs_scanner (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .fail_valid   (fail_valid),
    .fail_block   (fail_block),
    .lk_block     (lk_block),
    .lk_bad       (lk_bad),
    .scan_done    (scan_done),
    .bad_count    (bad_count),
    .dev_fail     (dev_fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: expected read sequence from the marker layout (R2, R3)
  task automatic push_expected_reads();
    for (int b = 0; b < 128; b++) begin
      exp_q.push_back(19'(b * 4096));
      if (mk0[b] == 8'hFF) exp_q.push_back(19'(b * 4096 + 128));
    end
  endtask

  task automatic lookup(input int blk, input bit exp_bad, input string req);
    @(negedge clk);
    lk_block = 7'(blk);
    @(negedge clk);
    chk(lk_bad == exp_bad, req, int'(lk_bad), int'(exp_bad));
  endtask

  task automatic report_fail(input int blk);
    @(negedge clk);
    fail_valid = 1'b1;
    fail_block = 7'(blk);
    @(negedge clk);
    fail_valid = 1'b0;
  endtask

  // Monitor / responder: pops the scoreboard and answers each read
  initial begin
    logic [18:0] e;
    logic [18:0] a;
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = 8'h00;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (rd_req) begin
        a = rd_addr;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 read after scan end", int'(a), -1);
        end else begin
          e = exp_q.pop_front();
          chk(a == e, "R2/R3 read address", int'(a), int'(e));
        end
        repeat (2) @(negedge clk);
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = (a[11:7] == 5'd0) ? mk0[a[18:12]] : mk1[a[18:12]];
        @(negedge clk);
        rd_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    fail_valid = 1'b0;
    fail_block = '0;
    lk_block   = '0;
    for (int b = 0; b < 128; b++) begin
      mk0[b] = 8'hFF;
      mk1[b] = 8'hFF;
    end
    mk0[0]   = 8'h00;   // ignored: block 0 always good (R4)
    mk0[5]   = 8'h00;   // page-0 marker bad, page 1 skipped (R3)
    mk1[9]   = 8'h7F;   // page-1 marker bad (R3)
    mk1[127] = 8'h00;   // last block bad (R5 boundary)
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(scan_done == 1'b0, "R1 scan_done", int'(scan_done), 0);
    chk(bad_count == 8'd0, "R1 bad_count", int'(bad_count), 0);
    chk(dev_fail == 1'b0, "R1 dev_fail", int'(dev_fail), 0);
    chk(lk_bad == 1'b0, "R1 lk_bad", int'(lk_bad), 0);
    chk(rd_req == 1'b0, "R1 rd_req", int'(rd_req), 0);
    push_expected_reads();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R8 failure during scan, before the scan reaches block 9
    report_fail(9);
    chk(bad_count == 8'd1, "R8 count after early failure", int'(bad_count), 1);
    // R6 lookup gated while scan is running
    lookup(9, 1'b0, "R6 lookup before done");
    while (!scan_done) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads issued before done", exp_q.size(), 0);
    repeat (10) @(negedge clk);
    chk(scan_done == 1'b1, "R5 done stays high", int'(scan_done), 1);
    chk(bad_count == 8'd3, "R7/R8 count no double count", int'(bad_count), 3);
    chk(dev_fail == 1'b0, "R7 dev_fail at 3", int'(dev_fail), 0);
    // R3/R4 full table sweep
    for (int b = 0; b < 128; b++) begin
      lookup(b, (b == 5) || (b == 9) || (b == 127), "R3/R4 table entry");
    end
    // R8 run-time failure after scan, crossing the limit
    report_fail(40);
    chk(bad_count == 8'd4, "R8 count after new failure", int'(bad_count), 4);
    chk(dev_fail == 1'b1, "R7 dev_fail above 3", int'(dev_fail), 1);
    lookup(40, 1'b1, "R8 failed block bad");
    report_fail(40);
    chk(bad_count == 8'd4, "R8 repeat failure not counted", int'(bad_count), 4);
    report_fail(0);
    chk(bad_count == 8'd4, "R4 failure on block 0 not counted", int'(bad_count), 4);
    lookup(0, 1'b0, "R4 block 0 still good");
    lookup(41, 1'b0, "R8 neighbour untouched");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule